// File: doc/BRIEF.md
# Interrupt Priority Arbiter

This block is the selection stage of a nested interrupt controller. It keeps a priority byte for every device interrupt line, reachable through a small byte-addressed register bus, and a pending bit and an enable bit for each line. In every cycle it picks the most urgent request among the lines that are both pending and enabled, and reports that request's exception number and priority. Each priority byte stores only its upper `PRIO_BITS` bits. A lower numeric value is more urgent.

Three core exceptions have fixed priorities and rank above every configurable level. These are system reset, the non-maskable interrupt and the hard fault. The enable bits have no effect on them. The block also compares the winning priority against the priority of the handler that is currently running, and it raises a preemption request when the winner is more urgent. Elaboration fails when `PRIO_BITS` is below the profile minimum or above 8.

The winner's priority is reported as a signed rank. Reset is -3, NMI is -2, hard fault is -1, and a device line reports its stored byte value from 0 to 255.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset, every priority byte reads 0, all pending and enable bits are clear, and with no fixed exception asserted `valid_o` is 0.
- R2: A priority write stores only bits [7:8-PRIO_BITS] of the data. The lower bits read as zero. With PRIO_BITS=3, writing 0xFF reads back 0xE0 and writing 0x5A reads back 0x40.
- R3: The byte for device line k sits at address BASE_ADDR+k. A write to an address outside BASE_ADDR..BASE_ADDR+NUM_IRQ-1 changes no byte, and a read there returns 0.
- R4: A priority write affects `reg_rdata_o` and the arbitration from the cycle after the write edge, and not before it.
- R5: Among lines that are both pending and enabled, the one with the numerically smallest priority byte wins.
- R6: When priorities are equal, the line with the lower exception number wins.
- R7: Only a line that is pending and enabled competes. When a set and a clear for a pending bit or an enable bit arrive in the same cycle, the clear wins.
- R8: A winning device line k gives `exc_num_o` = 16+k and `win_prio_o` = its byte value, with `win_fixed_o` = 0.
- R9: The fixed exceptions beat all device lines whatever the enables are set to. The order is reset (exception 1, rank -3), then NMI (2, -2), then hard fault (3, -1), and `win_fixed_o` is 1 for each of them.
- R10: `preempt_o` is 1 only when a winner exists and its rank is strictly less than `active_prio_i`. An equal rank gives 0.
- R11: With no winner, `valid_o`, `exc_num_o`, `win_prio_o`, `win_fixed_o` and `preempt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Priority byte write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the priority register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| pend_set_i | input | NUM_IRQ | Sets the pending bit of each line |
| pend_clr_i | input | NUM_IRQ | Clears the pending bit of each line |
| en_set_i | input | NUM_IRQ | Sets the enable bit of each line |
| en_clr_i | input | NUM_IRQ | Clears the enable bit of each line |
| reset_req_i | input | 1 | Fixed-priority reset request |
| nmi_i | input | 1 | Non-maskable interrupt request |
| hardfault_i | input | 1 | Hard fault request |
| active_prio_i | input | 10 | Signed rank of the running handler |
| valid_o | output | 1 | A winner exists |
| exc_num_o | output | EXC_W | Exception number of the winner |
| win_prio_o | output | 10 | Signed rank of the winner |
| win_fixed_o | output | 1 | The winner is a fixed exception |
| preempt_o | output | 1 | The winner is more urgent than the active handler |

## Verification
The assertions assume that `reg_addr_i` is steady within each cycle and that `active_prio_i` is a legal rank between -3 and 256. The readback property also assumes that a write is only judged when the address is held into the following cycle. The stimulus drives every input on the falling edge. It holds the address steady across each write and its readback, and it uses only active ranks from that range.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int EXC_RESET     = 1;
  localparam int EXC_NMI       = 2;
  localparam int EXC_HARDFAULT = 3;
  localparam int EXC_DEV_BASE  = 16;
  localparam int RANK_W        = 10;
  localparam int MIN_PRIO_BITS = 2;

  typedef logic signed [RANK_W-1:0] rank_t;
  typedef logic [7:0] prio_byte_t;

  localparam rank_t RANK_RESET     = -10'sd3;
  localparam rank_t RANK_NMI       = -10'sd2;
  localparam rank_t RANK_HARDFAULT = -10'sd1;
endpackage

// File: rtl/prio_regfile.sv
module prio_regfile
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [7:0]                      wdata_i,
  output logic [7:0]                      rdata_o,
  output logic [NUM_IRQ-1:0][7:0]         prio_o
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int LOW_W = 8 - PRIO_BITS;

  logic [ADDR_W-1:0] off;
  logic              in_rng;
  logic [IDX_W-1:0]  idx;

  assign off    = addr_i - ADDR_W'(BASE_ADDR);
  assign in_rng = (addr_i >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(NUM_IRQ));
  assign idx    = off[IDX_W-1:0];

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_byte
    logic [PRIO_BITS-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= '0;
      else if (we_i && in_rng && idx == IDX_W'(k)) q <= wdata_i[7 -: PRIO_BITS];
    end
    assign prio_o[k] = 8'(q) << LOW_W;
  end

  always_comb begin
    rdata_o = '0;
    if (in_rng) rdata_o = prio_o[idx];
  end
endmodule

// File: rtl/irq_line_state.sv
module irq_line_state #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] pend_set_i,
  input  logic [NUM_IRQ-1:0] pend_clr_i,
  input  logic [NUM_IRQ-1:0] en_set_i,
  input  logic [NUM_IRQ-1:0] en_clr_i,
  output logic [NUM_IRQ-1:0] req_o
);
  logic [NUM_IRQ-1:0] pend_q, en_q;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    // clear has priority over set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[k] <= 1'b0;
        en_q[k]   <= 1'b0;
      end else begin
        if (pend_clr_i[k])      pend_q[k] <= 1'b0;
        else if (pend_set_i[k]) pend_q[k] <= 1'b1;
        if (en_clr_i[k])        en_q[k]   <= 1'b0;
        else if (en_set_i[k])   en_q[k]   <= 1'b1;
      end
    end
  end

  assign req_o = pend_q & en_q;
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0]      req_i,
  input  logic [NUM_IRQ-1:0][7:0] prio_i,
  output logic                    valid_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [7:0]              prio_o
);
  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (req_i[k] && (!valid_o || prio_i[k] < prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(k);
        prio_o  = prio_i[k];
      end
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 16,
  localparam int EXC_W    = $clog2(NUM_IRQ + EXC_DEV_BASE)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [7:0]               reg_wdata_i,
  output logic [7:0]               reg_rdata_o,
  input  logic [NUM_IRQ-1:0]       pend_set_i,
  input  logic [NUM_IRQ-1:0]       pend_clr_i,
  input  logic [NUM_IRQ-1:0]       en_set_i,
  input  logic [NUM_IRQ-1:0]       en_clr_i,
  input  logic                     reset_req_i,
  input  logic                     nmi_i,
  input  logic                     hardfault_i,
  input  logic signed [RANK_W-1:0] active_prio_i,
  output logic                     valid_o,
  output logic [EXC_W-1:0]         exc_num_o,
  output logic signed [RANK_W-1:0] win_prio_o,
  output logic                     win_fixed_o,
  output logic                     preempt_o
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  if (PRIO_BITS < MIN_PRIO_BITS || PRIO_BITS > 8) begin : g_bad_prio_bits
    $error("irq_prio_arb: PRIO_BITS out of legal range");
  end

  logic [NUM_IRQ-1:0][7:0] prio;
  logic [NUM_IRQ-1:0]      req;
  logic                    dev_valid;
  logic [IDX_W-1:0]        dev_idx;
  logic [7:0]              dev_prio;

  prio_regfile #(
    .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .prio_o(prio)
  );

  irq_line_state #(.NUM_IRQ(NUM_IRQ)) u_lines (
    .clk_i, .rst_ni,
    .pend_set_i, .pend_clr_i, .en_set_i, .en_clr_i,
    .req_o(req)
  );

  prio_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .req_i(req), .prio_i(prio),
    .valid_o(dev_valid), .idx_o(dev_idx), .prio_o(dev_prio)
  );

  always_comb begin
    valid_o     = 1'b1;
    win_fixed_o = 1'b1;
    exc_num_o   = '0;
    win_prio_o  = '0;
    if (reset_req_i) begin
      exc_num_o  = EXC_W'(EXC_RESET);
      win_prio_o = RANK_RESET;
    end else if (nmi_i) begin
      exc_num_o  = EXC_W'(EXC_NMI);
      win_prio_o = RANK_NMI;
    end else if (hardfault_i) begin
      exc_num_o  = EXC_W'(EXC_HARDFAULT);
      win_prio_o = RANK_HARDFAULT;
    end else if (dev_valid) begin
      win_fixed_o = 1'b0;
      exc_num_o   = EXC_W'(EXC_DEV_BASE) + EXC_W'(dev_idx);
      win_prio_o  = $signed({2'b00, dev_prio});
    end else begin
      valid_o     = 1'b0;
      win_fixed_o = 1'b0;
    end
  end

  assign preempt_o = valid_o && (win_prio_o < active_prio_i);
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 16,
  localparam int EXC_W    = $clog2(NUM_IRQ + EXC_DEV_BASE)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     reg_we_i,
  input logic [ADDR_W-1:0]        reg_addr_i,
  input logic [7:0]               reg_wdata_i,
  input logic [7:0]               reg_rdata_o,
  input logic [NUM_IRQ-1:0]       pend_set_i,
  input logic [NUM_IRQ-1:0]       pend_clr_i,
  input logic [NUM_IRQ-1:0]       en_set_i,
  input logic [NUM_IRQ-1:0]       en_clr_i,
  input logic                     reset_req_i,
  input logic                     nmi_i,
  input logic                     hardfault_i,
  input logic signed [RANK_W-1:0] active_prio_i,
  input logic                     valid_o,
  input logic [EXC_W-1:0]         exc_num_o,
  input logic signed [RANK_W-1:0] win_prio_o,
  input logic                     win_fixed_o,
  input logic                     preempt_o
);
  localparam logic [7:0] HI_MASK  = 8'hFF << (8 - PRIO_BITS);
  localparam logic [7:0] LOW_MASK = ~HI_MASK;

  logic in_rng, seen_q;
  assign in_rng = (reg_addr_i >= ADDR_W'(BASE_ADDR)) &&
                  ((reg_addr_i - ADDR_W'(BASE_ADDR)) < ADDR_W'(NUM_IRQ));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R2
  low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & LOW_MASK) == 8'h00);

  // R4
  write_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(reg_we_i && in_rng) && $stable(reg_addr_i))
      |-> reg_rdata_o == ($past(reg_wdata_i) & HI_MASK));

  // R3
  out_of_range_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rng |-> reg_rdata_o == 8'h00);

  // R9
  reset_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |-> (exc_num_o == EXC_W'(EXC_RESET)) && win_fixed_o);

  // R9
  nmi_over_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !reset_req_i) |-> exc_num_o == EXC_W'(EXC_NMI));

  // R8
  device_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !win_fixed_o) |-> (exc_num_o >= EXC_W'(EXC_DEV_BASE)) && (win_prio_o >= 0));

  // R10
  preempt_strict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preempt_o |-> valid_o && (win_prio_o < active_prio_i));

  // R11
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (exc_num_o == '0) && !preempt_o && !win_fixed_o);
endmodule

bind irq_prio_arb irq_prio_arb_chk #(
  .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (.*);

// File: tb/irq_prio_arb_bench.sv
`timescale 1ns/1ps
module irq_prio_arb_bench;
  localparam int NUM_IRQ   = 8;
  localparam int PRIO_BITS = 3;
  localparam int ADDR_W    = 8;
  localparam int BASE_ADDR = 16;
  localparam int EXC_W     = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NUM_IRQ-1:0] pset = '0, pclr = '0, eset = '0, eclr = '0;
  logic rst_req = 1'b0, nmi = 1'b0, hf = 1'b0;
  logic signed [9:0] active = 10'sd256;
  logic valid, wfix, preempt;
  logic [EXC_W-1:0] exc;
  logic signed [9:0] wprio;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_prio_arb #(
    .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_irq_prio_arb (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pend_set_i(pset), .pend_clr_i(pclr), .en_set_i(eset), .en_clr_i(eclr),
    .reset_req_i(rst_req), .nmi_i(nmi), .hardfault_i(hf),
    .active_prio_i(active),
    .valid_o(valid), .exc_num_o(exc), .win_prio_o(wprio),
    .win_fixed_o(wfix), .preempt_o(preempt)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 0; pset = '0; pclr = '0; eset = '0; eclr = '0;
    rst_req = 0; nmi = 0; hf = 0; active = 10'sd256;
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr(input int k_addr, input int d);
    addr = ADDR_W'(k_addr); wdata = 8'(d); we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int k_addr, input int exp);
    addr = ADDR_W'(k_addr);
    #0.5;
    chk(req, int'(rdata), exp);
  endtask

  task automatic win_chk(input string req, input int v, input int e, input int p, input int f);
    chk({req, " valid"}, int'(valid), v);
    chk({req, " exc"}, int'(exc), e);
    chk({req, " prio"}, int'(wprio), p);
    chk({req, " fixed"}, int'(wfix), f);
  endtask

  task automatic t_reset();
    do_reset();
    for (int k = 0; k < NUM_IRQ; k++) rd_chk("R1 byte", BASE_ADDR + k, 0);
    eset = '1; step(); eset = '0;
    win_chk("R1 idle", 0, 0, 0, 0);
    chk("R11 preempt", int'(preempt), 0);
  endtask

  task automatic t_regs();
    do_reset();
    wr(BASE_ADDR + 0, 8'hFF);
    rd_chk("R2 ff", BASE_ADDR + 0, 8'hE0);
    wr(BASE_ADDR + 3, 8'h5A);
    rd_chk("R2 5a", BASE_ADDR + 3, 8'h40);
    wr(BASE_ADDR + NUM_IRQ, 8'hFF);
    wr(BASE_ADDR - 1, 8'hFF);
    rd_chk("R3 above", BASE_ADDR + NUM_IRQ, 0);
    rd_chk("R3 below", BASE_ADDR - 1, 0);
    rd_chk("R3 last", BASE_ADDR + NUM_IRQ - 1, 0);
    rd_chk("R3 first", BASE_ADDR + 0, 8'hE0);
    rd_chk("R3 line3", BASE_ADDR + 3, 8'h40);
  endtask

  task automatic t_arb();
    do_reset();
    wr(BASE_ADDR + 2, 8'h60);
    wr(BASE_ADDR + 5, 8'h20);
    wr(BASE_ADDR + 6, 8'h20);
    eset = '1; pset = 8'b0110_0100; step(); eset = '0; pset = '0;
    win_chk("R5 R6 R8 tie", 1, 21, 32, 0);
    pclr = 8'b0010_0000; step(); pclr = '0;
    win_chk("R5 after clr", 1, 22, 32, 0);
    eclr = 8'b0100_0000; step(); eclr = '0;
    win_chk("R7 disabled", 1, 18, 96, 0);
    // simultaneous set and clear: clear wins
    pset = 8'b0000_0010; pclr = 8'b0000_0010; step(); pset = '0; pclr = '0;
    win_chk("R7 pend clr wins", 1, 18, 96, 0);
    eclr = 8'b0000_0100; eset = 8'b0000_0100; step(); eclr = '0; eset = '0;
    win_chk("R7 en clr wins", 0, 0, 0, 0);
    chk("R11 preempt idle", int'(preempt), 0);
  endtask

  task automatic t_timing();
    do_reset();
    wr(BASE_ADDR + 2, 8'h60);
    wr(BASE_ADDR + 4, 8'h80);
    eset = '1; pset = 8'b0001_0100; step(); eset = '0; pset = '0;
    win_chk("R4 before", 1, 18, 96, 0);
    addr = ADDR_W'(BASE_ADDR + 4); wdata = 8'h00; we = 1'b1;
    #0.5;
    win_chk("R4 same cycle", 1, 18, 96, 0);
    chk("R4 rdata same cycle", int'(rdata), 8'h80);
    step(); we = 1'b0;
    win_chk("R4 next cycle", 1, 20, 0, 0);
    chk("R4 rdata next", int'(rdata), 0);
  endtask

  task automatic t_fixed();
    do_reset();
    wr(BASE_ADDR + 1, 8'h00);
    eset = '1; pset = 8'b0000_0010; step(); eset = '0; pset = '0;
    hf = 1; #0.5;
    win_chk("R9 hardfault", 1, 3, -1, 1);
    nmi = 1; #0.5;
    win_chk("R9 nmi", 1, 2, -2, 1);
    rst_req = 1; #0.5;
    win_chk("R9 reset", 1, 1, -3, 1);
    eclr = '1; step(); eclr = '0;
    win_chk("R9 enables off", 1, 1, -3, 1);
    rst_req = 0; nmi = 0; #0.5;
    win_chk("R9 hf unmaskable", 1, 3, -1, 1);
    hf = 0;
  endtask

  task automatic t_preempt();
    do_reset();
    wr(BASE_ADDR + 5, 8'h20);
    eset = '1; pset = 8'b0010_0000; step(); eset = '0; pset = '0;
    active = 10'sd96; #0.5;
    chk("R10 lower wins", int'(preempt), 1);
    active = 10'sd32; #0.5;
    chk("R10 equal no", int'(preempt), 0);
    active = 10'sd0; #0.5;
    chk("R10 higher active", int'(preempt), 0);
    nmi = 1; active = -10'sd1; #0.5;
    chk("R10 nmi over hf", int'(preempt), 1);
    active = -10'sd2; #0.5;
    chk("R10 nmi equal", int'(preempt), 0);
    nmi = 0; active = 10'sd256;
  endtask

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_arb();
    t_timing();
    t_fixed();
    t_preempt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule